// File: doc/BRIEF.md
# Direction-Configurable Control Pass-Through Cell

This cell sits inside every tile of a tiled chip whose tile layouts are reused with vertical mirroring. It carries a group of six wrapper serial control signals through the tile: wrapper clock, active-low wrapper reset, shift, update, capture and instruction-register select. The tile has two bidirectional edge ports, called primary and secondary. Each is modelled as a separate input vector, output vector and per-bit output-enable vector, so the pad and bidirectional buffer stay outside the block.

A static orientation input, tied high or low when the chip is put together, decides which edge receives and which edge drives. The received group is repeated on the opposite edge. It is also handed to the tile's own wrapper serial port. Before the two edges are merged onto the local port, each edge's input is gated with its own orientation term. A floating or stray level on the idle edge therefore cannot reach the tile. The cell is purely combinational.

Top module: `ctl_passthru`

## Requirements
- R1: With orient_i = 1, sec_o equals pri_i bit for bit and every bit of sec_oe_o is 1 (upward repeat, primary to secondary).
- R2: With orient_i = 0, pri_o equals sec_i bit for bit and every bit of pri_oe_o is 1 (downward repeat, secondary to primary).
- R3: The receiving edge never drives: pri_oe_o is all 0 when orient_i = 1, and sec_oe_o is all 0 when orient_i = 0.
- R4: The data output of the receiving edge is all 0 (pri_o when orient_i = 1, sec_o when orient_i = 0).
- R5: The local port carries the receiving edge's group with this fixed bit mapping: bit 0 to wr_clk_o, bit 1 to wr_rst_no, bit 2 to shift_o, bit 3 to update_o, bit 4 to capture_o, bit 5 to sel_ir_o.
- R6: The input vector of the idle edge (sec_i when orient_i = 1, pri_i when orient_i = 0) has no effect on any output.
- R7: The active-low reset at bit 1 reaches wr_rst_no at its unmodified level in both orientations, including when the idle edge holds bit 1 at 0 or at 1.
- R8: Outputs depend only on the present inputs: a change on the receiving edge appears on all outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| orient_i | input | 1 | Static orientation tie: 1 = primary receives, 0 = secondary receives |
| pri_i | input | 6 | Primary edge input group |
| pri_o | output | 6 | Primary edge output group |
| pri_oe_o | output | 6 | Primary edge per-bit output enable |
| sec_i | input | 6 | Secondary edge input group |
| sec_o | output | 6 | Secondary edge output group |
| sec_oe_o | output | 6 | Secondary edge per-bit output enable |
| wr_clk_o | output | 1 | Local wrapper clock |
| wr_rst_no | output | 1 | Local wrapper reset, active low |
| shift_o | output | 1 | Local shift control |
| update_o | output | 1 | Local update control |
| capture_o | output | 1 | Local capture control |
| sel_ir_o | output | 1 | Local instruction-register select |

## Verification
The hardest case to reach is a corrupting level on the idle edge: a line that looks undriven yet sits at 1 on a bit where the active edge holds 0. A faulty gate would let that 1 leak through the OR merge. The bench drives the idle edge with random vectors that are independent of the active edge. It also drives the idle edge with all ones and all zeros while the active reset bit is held at 0 and at 1. It then checks the local port and both edge outputs against a model that only looks at the active edge.

// File: rtl/ctl_pt_pkg.sv
package ctl_pt_pkg;
  localparam int unsigned CTRL_W  = 6;
  localparam int unsigned N_SIDES = 2;
  localparam int unsigned SIDE_PRI = 0;
  localparam int unsigned SIDE_SEC = 1;

  localparam int unsigned B_CLK   = 0;
  localparam int unsigned B_RSTN  = 1;
  localparam int unsigned B_SHIFT = 2;
  localparam int unsigned B_UPD   = 3;
  localparam int unsigned B_CAP   = 4;
  localparam int unsigned B_SELIR = 5;

  typedef logic [CTRL_W-1:0] ctl_vec_t;
endpackage

// File: rtl/ctl_dir_dec.sv
module ctl_dir_dec #(
  parameter int unsigned W = 6
) (
  input  logic         orient_i,
  output logic         pri_rx_en_o,
  output logic         sec_rx_en_o,
  output logic [W-1:0] pri_oe_o,
  output logic [W-1:0] sec_oe_o
);
  // orientation 1: primary receives, secondary drives
  assign pri_rx_en_o = orient_i;
  assign sec_rx_en_o = ~orient_i;
  assign sec_oe_o    = {W{orient_i}};
  assign pri_oe_o    = {W{~orient_i}};
endmodule

// File: rtl/ctl_gate.sv
module ctl_gate #(
  parameter int unsigned W = 6
) (
  input  logic         en_i,
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] vec_o
);
  assign vec_o = vec_i & {W{en_i}};
endmodule

// File: rtl/ctl_merge.sv
module ctl_merge #(
  parameter int unsigned W = 6,
  parameter int unsigned N = 2
) (
  input  logic [N-1:0][W-1:0] vec_i,
  output logic [W-1:0]        vec_o
);
  logic [N:0][W-1:0] acc;
  assign acc[0] = '0;
  for (genvar n = 0; n < N; n++) begin : g_or
    assign acc[n+1] = acc[n] | vec_i[n];
  end
  assign vec_o = acc[N];
endmodule

// File: rtl/ctl_passthru.sv
module ctl_passthru
  import ctl_pt_pkg::*;
(
  input  logic        orient_i,
  input  logic [5:0]  pri_i,
  output logic [5:0]  pri_o,
  output logic [5:0]  pri_oe_o,
  input  logic [5:0]  sec_i,
  output logic [5:0]  sec_o,
  output logic [5:0]  sec_oe_o,
  output logic        wr_clk_o,
  output logic        wr_rst_no,
  output logic        shift_o,
  output logic        update_o,
  output logic        capture_o,
  output logic        sel_ir_o
);
  logic [N_SIDES-1:0]             rx_en;
  logic [N_SIDES-1:0][CTRL_W-1:0] rx_vec;
  logic [N_SIDES-1:0][CTRL_W-1:0] gated;
  ctl_vec_t                       local_vec;

  ctl_dir_dec #(.W(CTRL_W)) u_dec (
    .orient_i    (orient_i),
    .pri_rx_en_o (rx_en[SIDE_PRI]),
    .sec_rx_en_o (rx_en[SIDE_SEC]),
    .pri_oe_o    (pri_oe_o),
    .sec_oe_o    (sec_oe_o)
  );

  assign rx_vec[SIDE_PRI] = pri_i;
  assign rx_vec[SIDE_SEC] = sec_i;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    ctl_gate #(.W(CTRL_W)) u_gate (
      .en_i  (rx_en[s]),
      .vec_i (rx_vec[s]),
      .vec_o (gated[s])
    );
  end

  // each edge repeats the opposite edge's gated group; idle direction reads 0
  assign sec_o = gated[SIDE_PRI];
  assign pri_o = gated[SIDE_SEC];

  ctl_merge #(.W(CTRL_W), .N(N_SIDES)) u_merge (
    .vec_i (gated),
    .vec_o (local_vec)
  );

  assign wr_clk_o  = local_vec[B_CLK];
  assign wr_rst_no = local_vec[B_RSTN];
  assign shift_o   = local_vec[B_SHIFT];
  assign update_o  = local_vec[B_UPD];
  assign capture_o = local_vec[B_CAP];
  assign sel_ir_o  = local_vec[B_SELIR];
endmodule

// File: rtl/ctl_passthru_chk.sv
module ctl_passthru_chk (
  input logic       orient_i,
  input logic [5:0] pri_i,
  input logic [5:0] pri_o,
  input logic [5:0] pri_oe_o,
  input logic [5:0] sec_i,
  input logic [5:0] sec_o,
  input logic [5:0] sec_oe_o,
  input logic       wr_clk_o,
  input logic       wr_rst_no,
  input logic       shift_o,
  input logic       update_o,
  input logic       capture_o,
  input logic       sel_ir_o
);
  logic [5:0] loc;
  logic [5:0] act;
  assign loc = {sel_ir_o, capture_o, update_o, shift_o, wr_rst_no, wr_clk_o};
  assign act = orient_i ? pri_i : sec_i;

  always_comb begin
    a_r1_up_repeat:   assert (!orient_i || (sec_o == pri_i && &sec_oe_o));
    a_r2_dn_repeat:   assert (orient_i || (pri_o == sec_i && &pri_oe_o));
    a_r3_rx_hiz:      assert (orient_i ? (pri_oe_o == '0) : (sec_oe_o == '0));
    a_r4_rx_data_low: assert (orient_i ? (pri_o == '0) : (sec_o == '0));
    a_r5_local_map:   assert (loc == act);
    a_r7_rstn_level:  assert (wr_rst_no == act[1]);
    a_r3_oe_exclusive: assert ((pri_oe_o & sec_oe_o) == '0);
  end
endmodule

bind ctl_passthru ctl_passthru_chk u_chk (.*);

// File: tb/ctl_passthru_tb_top.sv
`timescale 1ns/1ps
module ctl_passthru_tb_top;
  logic       clk;
  logic       orient;
  logic [5:0] pri_i, sec_i;
  logic [5:0] pri_o, pri_oe, sec_o, sec_oe;
  logic       wr_clk, wr_rst_n, shift, update, capture, sel_ir;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  ctl_passthru dut_i (
    .orient_i (orient), .pri_i (pri_i), .pri_o (pri_o), .pri_oe_o (pri_oe),
    .sec_i (sec_i), .sec_o (sec_o), .sec_oe_o (sec_oe),
    .wr_clk_o (wr_clk), .wr_rst_no (wr_rst_n), .shift_o (shift),
    .update_o (update), .capture_o (capture), .sel_ir_o (sel_ir)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: only the receiving edge matters
  task automatic compare_all();
    int rx;
    int local_exp;
    rx = orient ? int'(pri_i) : int'(sec_i);
    local_exp = rx;
    if (orient) begin
      check("R1 sec_o", int'(sec_o), rx);
      check("R1 sec_oe", int'(sec_oe), 'h3f);
      check("R3 pri_oe", int'(pri_oe), 0);
      check("R4 pri_o", int'(pri_o), 0);
    end else begin
      check("R2 pri_o", int'(pri_o), rx);
      check("R2 pri_oe", int'(pri_oe), 'h3f);
      check("R3 sec_oe", int'(sec_oe), 0);
      check("R4 sec_o", int'(sec_o), 0);
    end
    check("R5 wr_clk",  int'(wr_clk),  (local_exp >> 0) & 1);
    check("R7 wr_rst_n", int'(wr_rst_n), (local_exp >> 1) & 1);
    check("R5 shift",   int'(shift),   (local_exp >> 2) & 1);
    check("R5 update",  int'(update),  (local_exp >> 3) & 1);
    check("R5 capture", int'(capture), (local_exp >> 4) & 1);
    check("R5 sel_ir",  int'(sel_ir),  (local_exp >> 5) & 1);
  endtask

  task automatic apply(input logic o, input logic [5:0] p, input logic [5:0] s);
    @(negedge clk);
    orient = o; pri_i = p; sec_i = s;
    #8;
    compare_all();
  endtask

  initial begin
    orient = 1'b1; pri_i = '0; sec_i = '0;
    #5;
    // idle-start state: all-zero inputs, orientation up
    check("R3 init pri_oe", int'(pri_oe), 0);
    check("R4 init pri_o", int'(pri_o), 0);
    check("R7 init rst_n", int'(wr_rst_n), 0);

    for (int k = 0; k < 2; k++) begin
      logic o;
      o = (k == 0);
      // random active and independent idle edge (R6)
      for (int i = 0; i < 300; i++)
        apply(o, 6'($urandom), 6'($urandom));
      // R7: reset bit against hostile idle levels
      apply(o, o ? 6'b000000 : 6'b111111, o ? 6'b111111 : 6'b000000);
      apply(o, o ? 6'b000010 : 6'b000000, o ? 6'b000000 : 6'b000010);
      apply(o, o ? 6'b111101 : 6'b000010, o ? 6'b000010 : 6'b111101);
      // R6: idle edge toggles, outputs must not move
      for (int i = 0; i < 20; i++) begin
        logic [5:0] keep;
        logic [5:0] p0, s0, pr, sr, l0;
        keep = 6'($urandom);
        apply(o, o ? keep : 6'h3f, o ? 6'h00 : keep);
        p0 = pri_o; s0 = sec_o;
        l0 = {sel_ir, capture, update, shift, wr_rst_n, wr_clk};
        apply(o, o ? keep : 6'($urandom), o ? 6'($urandom) : keep);
        pr = pri_o; sr = sec_o;
        check("R6 pri_o steady", int'(pr), int'(p0));
        check("R6 sec_o steady", int'(sr), int'(s0));
        check("R6 local steady",
              int'({sel_ir, capture, update, shift, wr_rst_n, wr_clk}), int'(l0));
      end
    end

    // R8: mid-cycle change with no clock edge in between
    @(posedge clk); #2;
    orient = 1'b0; sec_i = 6'h2a; pri_i = 6'h15;
    #1;
    check("R8 comb pri_o", int'(pri_o), 'h2a);
    check("R8 comb local", int'({sel_ir, capture, update, shift, wr_rst_n, wr_clk}), 'h2a);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule